// File: doc/BRIEF.md
# Multi-Mode Timer Waveform Generator

A counter with a set of compare channels that drives one waveform output per channel. It advances only on cycles where the count-enable tick is high. The mode input picks one of seven behaviours:

- two frequency modes, where each output toggles on a compare match;
- one single-slope pulse-width mode;
- four dual-slope pulse-width modes, which differ only in where the overflow flag is raised.

The mode also decides where the counter's ceiling (TOP) comes from and when buffered values take effect. In the match-period toggle mode, TOP is the channel 0 compare value; in all other modes it is the period register.

Software-side writes to the period and compare registers land in shadow buffers. Those buffers are copied into the active registers only at the mode's update point:

- for single-slope modes, the wrap of the counter;
- for dual-slope modes, the bottom of the count.

Each channel has:

- a sticky match flag that feeds a shared interrupt line;
- a gated event strobe;
- an always-on DMA request strobe;
- an output inversion bit.

The block also has an overflow flag and an overflow strobe.

Top module: `tmr_wavegen`

## Requirements
- R1: The mode code selects the behaviour as follows: 0 free toggle, 1 match-period toggle, 2 single-slope PWM, 3 behaves as 2, 4 dual-slope bottom-critical, 5 dual-slope bottom, 6 dual-slope both, 7 dual-slope top. In mode 1, TOP is the active channel 0 compare value. In every other mode, TOP is the active period value.
- R2: The counter moves only on a clock edge where `tick` is 1. In single-slope modes with `cnt_down`=0 it counts up and goes from TOP to 0. With `cnt_down`=1 it counts down and goes from 0 to TOP.
- R3: In dual-slope modes the counter runs 0,1,…,TOP,TOP-1,…,1,0,1,… with one tick at each turning point. When TOP is 0 it stays at 0.
- R4: In single-slope modes, a period or compare value written through `per_we`/`cc_we` becomes active only at the tick where the counter wraps.
- R5: In dual-slope modes, buffered values become active only at the tick where the counter turns at 0.
- R6: In modes 0 and 1, a channel's raw output toggles on every tick where the count equals that channel's active compare value, and it keeps its level otherwise, including at updates.
- R7: In modes 2 to 7, a channel's raw output is 1 while count < compare value and 0 otherwise, on both slopes.
- R8: `wo[i]` is the raw output XOR `inv_en[i]`.
- R9: In single-slope modes, overflow is raised at the wrap: at TOP when counting up and at 0 when counting down. Each overflow gives a one-cycle `ovf_evt` pulse and sets `ovf_flag`, which holds until `ovf_clr`.
- R10: In dual-slope modes, overflow is raised at the bottom turn in modes 4 and 5, at both turns in mode 6, and only at the top turn in mode 7.
- R11: A match sets `mc_flag[i]` on the tick that follows the clock edge at which the count became equal to the compare value. The flag stays set until `mc_clr[i]` is 1. `irq` is 1 when any set flag has its `irq_en` bit set.
- R12: Each match gives a one-cycle `dma_req[i]` pulse. It gives a one-cycle `mc_evt[i]` pulse only when `evt_en[i]` is 1.
- R13: After reset, the counter, the active and buffered registers, all flags, all strobes and the toggle states are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable for this cycle |
| mode | input | 3 | Generation mode code |
| cnt_down | input | 1 | Count direction for single-slope modes |
| per_wdata | input | CW | Period value to buffer |
| per_we | input | 1 | Load `per_wdata` into the period buffer |
| cc_wdata | input | NCH*CW | Compare values, channel i at bits [i*CW +: CW] |
| cc_we | input | NCH | Per-channel load of the compare buffer |
| inv_en | input | NCH | Per-channel output inversion |
| irq_en | input | NCH | Per-channel interrupt enable |
| evt_en | input | NCH | Per-channel event strobe enable |
| mc_clr | input | NCH | Per-channel match flag clear |
| ovf_clr | input | 1 | Overflow flag clear |
| wo | output | NCH | Waveform outputs |
| mc_flag | output | NCH | Sticky match flags |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Combined interrupt |
| mc_evt | output | NCH | Match event strobes |
| ovf_evt | output | 1 | Overflow strobe |
| dma_req | output | NCH | Match DMA request strobes |

## Verification
Each of the seven modes runs for twelve ticks from a known start. The bench counts overflow strobes, match strobes, high output cycles and output transitions on one channel.

- The overflow counts separate the four dual-slope variants from each other and separate up-counting from down-counting.
- The transition and high-cycle counts separate toggling from compare-threshold output and catch a wrong TOP source or a missed inversion.

Directed runs cover several timing cases:

- a period write issued mid-period, in both slope families, to check that it waits for its update point;
- the one-tick delay of the match flag and its sticky behaviour;
- an event strobe that stays disabled while the DMA strobe keeps pulsing;
- a counter that stays frozen while `tick` is low.

// File: rtl/tmr_wavegen.sv
module tmr_wavegen #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [2:0]        mode,
  input  logic              cnt_down,
  input  logic [CW-1:0]     per_wdata,
  input  logic              per_we,
  input  logic [NCH*CW-1:0] cc_wdata,
  input  logic [NCH-1:0]    cc_we,
  input  logic [NCH-1:0]    inv_en,
  input  logic [NCH-1:0]    irq_en,
  input  logic [NCH-1:0]    evt_en,
  input  logic [NCH-1:0]    mc_clr,
  input  logic              ovf_clr,
  output logic [NCH-1:0]    wo,
  output logic [NCH-1:0]    mc_flag,
  output logic              ovf_flag,
  output logic              irq,
  output logic [NCH-1:0]    mc_evt,
  output logic              ovf_evt,
  output logic [NCH-1:0]    dma_req
);

  localparam logic [2:0] M_FTOG   = 3'd0;
  localparam logic [2:0] M_MTOG   = 3'd1;
  localparam logic [2:0] M_DSCRIT = 3'd4;
  localparam logic [2:0] M_DSBOT  = 3'd5;
  localparam logic [2:0] M_DSBOTH = 3'd6;
  localparam logic [2:0] M_DSTOP  = 3'd7;
  localparam logic [CW-1:0] ZERO  = '0;
  localparam logic [CW-1:0] ONE   = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0]  cnt, cnt_nxt, per_act, per_buf, top;
  logic           per_pend, slope_dn, slope_nxt;
  logic           ev_top, ev_zero, upd, ovf_hit;
  logic [CW-1:0]  cc_act [NCH];
  logic [CW-1:0]  cc_buf [NCH];
  logic [NCH-1:0] cc_pend, hit, below, tgl;

  wire dual = mode[2];
  wire freq = (mode == M_FTOG) || (mode == M_MTOG);

  assign top = (mode == M_MTOG) ? cc_act[0] : per_act;

  always_comb begin
    cnt_nxt   = cnt;
    slope_nxt = 1'b0;
    ev_top    = 1'b0;
    ev_zero   = 1'b0;
    if (dual) begin
      slope_nxt = slope_dn;
      if (top == ZERO) begin
        cnt_nxt   = ZERO;
        slope_nxt = 1'b0;
        ev_top    = 1'b1;
        ev_zero   = 1'b1;
      end else if (!slope_dn) begin
        if (cnt >= top) begin
          cnt_nxt   = cnt - ONE;
          slope_nxt = 1'b1;
          ev_top    = 1'b1;
        end else begin
          cnt_nxt = cnt + ONE;
        end
      end else if (cnt == ZERO) begin
        cnt_nxt   = ONE;
        slope_nxt = 1'b0;
        ev_zero   = 1'b1;
      end else begin
        cnt_nxt = cnt - ONE;
      end
    end else if (cnt_down) begin
      if (cnt == ZERO) begin
        cnt_nxt = top;
        ev_zero = 1'b1;
      end else begin
        cnt_nxt = cnt - ONE;
      end
    end else begin
      if (cnt >= top) begin
        cnt_nxt = ZERO;
        ev_top  = 1'b1;
      end else begin
        cnt_nxt = cnt + ONE;
      end
    end
  end

  assign upd = dual ? ev_zero : (ev_top | ev_zero);

  always_comb begin
    case (mode)
      M_DSCRIT, M_DSBOT: ovf_hit = ev_zero;
      M_DSBOTH:          ovf_hit = ev_top | ev_zero;
      M_DSTOP:           ovf_hit = ev_top;
      default:           ovf_hit = ev_top | ev_zero;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign hit[g]   = (cnt == cc_act[g]);
      assign below[g] = (cnt < cc_act[g]);
      assign wo[g]    = (freq ? tgl[g] : below[g]) ^ inv_en[g];
    end
  endgenerate

  assign irq = |(mc_flag & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= ZERO;
      slope_dn <= 1'b0;
      per_act  <= ZERO;
      per_buf  <= ZERO;
      per_pend <= 1'b0;
      cc_pend  <= '0;
      tgl      <= '0;
      mc_flag  <= '0;
      ovf_flag <= 1'b0;
      mc_evt   <= '0;
      ovf_evt  <= 1'b0;
      dma_req  <= '0;
      for (int i = 0; i < NCH; i++) begin
        cc_act[i] <= ZERO;
        cc_buf[i] <= ZERO;
      end
    end else begin
      if (tick) begin
        cnt      <= cnt_nxt;
        slope_dn <= slope_nxt;
      end
      if (tick && upd && per_pend) per_act <= per_buf;
      if (per_we) begin
        per_buf  <= per_wdata;
        per_pend <= 1'b1;
      end else if (tick && upd) begin
        per_pend <= 1'b0;
      end
      for (int i = 0; i < NCH; i++) begin
        if (tick && upd && cc_pend[i]) cc_act[i] <= cc_buf[i];
        if (cc_we[i]) begin
          cc_buf[i]  <= cc_wdata[i*CW +: CW];
          cc_pend[i] <= 1'b1;
        end else if (tick && upd) begin
          cc_pend[i] <= 1'b0;
        end
      end
      tgl      <= tgl ^ ({NCH{tick & freq}} & hit);
      mc_flag  <= (mc_flag & ~mc_clr) | ({NCH{tick}} & hit);
      ovf_flag <= (ovf_flag & ~ovf_clr) | (tick & ovf_hit);
      dma_req  <= {NCH{tick}} & hit;
      mc_evt   <= {NCH{tick}} & hit & evt_en;
      ovf_evt  <= tick & ovf_hit;
    end
  end

endmodule

// File: rtl/tmr_wavegen_chk.sv
module tmr_wavegen_chk #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic [CW-1:0]  cnt,
  input logic [NCH-1:0] mc_flag,
  input logic [NCH-1:0] mc_clr,
  input logic [NCH-1:0] mc_evt,
  input logic [NCH-1:0] evt_en,
  input logic [NCH-1:0] dma_req,
  input logic           ovf_evt,
  input logic           ovf_flag
);

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mc_flag & $past(mc_flag & ~mc_clr)) == $past(mc_flag & ~mc_clr)));

  assert_no_dma_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (dma_req == '0));

  assert_evt_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mc_evt & ~$past(evt_en)) == '0));

  assert_evt_with_dma_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((mc_evt & ~dma_req) == '0));

  assert_ovf_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> ovf_flag);

endmodule

bind tmr_wavegen tmr_wavegen_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt),
  .mc_flag(mc_flag), .mc_clr(mc_clr), .mc_evt(mc_evt), .evt_en(evt_en),
  .dma_req(dma_req), .ovf_evt(ovf_evt), .ovf_flag(ovf_flag)
);

// File: tb/sim_tmr_wavegen.sv
module sim_tmr_wavegen;
  localparam int CW  = 16;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [2:0] mode = '0;
  logic cnt_down = 1'b0;
  logic [CW-1:0] per_wdata = '0;
  logic per_we = 1'b0;
  logic [NCH*CW-1:0] cc_wdata = '0;
  logic [NCH-1:0] cc_we = '0, inv_en = '0, irq_en = '0, evt_en = '0, mc_clr = '0;
  logic ovf_clr = 1'b0;
  logic [NCH-1:0] wo, mc_flag, mc_evt, dma_req;
  logic ovf_flag, irq, ovf_evt;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  tmr_wavegen #(.CW(CW), .NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .cnt_down(cnt_down),
    .per_wdata(per_wdata), .per_we(per_we), .cc_wdata(cc_wdata), .cc_we(cc_we),
    .inv_en(inv_en), .irq_en(irq_en), .evt_en(evt_en), .mc_clr(mc_clr),
    .ovf_clr(ovf_clr), .wo(wo), .mc_flag(mc_flag), .ovf_flag(ovf_flag),
    .irq(irq), .mc_evt(mc_evt), .ovf_evt(ovf_evt), .dma_req(dma_req)
  );

  typedef struct packed {
    logic [2:0]  md;
    logic        dn;
    logic        inv;
    logic [15:0] per;
    logic [15:0] cc0;
    logic [15:0] cc1;
    logic [7:0]  e_ovf;
    logic [7:0]  e_dma;
    logic [7:0]  e_high;
    logic [7:0]  e_trans;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b0, 16'd3, 16'd9, 16'd1, 8'd3, 8'd3, 8'd5, 8'd3},
    '{3'd0, 1'b1, 1'b0, 16'd3, 16'd9, 16'd1, 8'd3, 8'd3, 8'd7, 8'd3},
    '{3'd1, 1'b0, 1'b0, 16'd7, 16'd2, 16'd1, 8'd4, 8'd4, 8'd6, 8'd4},
    '{3'd2, 1'b0, 1'b0, 16'd4, 16'd9, 16'd2, 8'd2, 8'd2, 8'd5, 8'd5},
    '{3'd2, 1'b0, 1'b1, 16'd4, 16'd9, 16'd2, 8'd2, 8'd2, 8'd7, 8'd5},
    '{3'd5, 1'b0, 1'b0, 16'd3, 16'd9, 16'd2, 8'd1, 8'd4, 8'd6, 8'd4},
    '{3'd6, 1'b0, 1'b0, 16'd3, 16'd9, 16'd2, 8'd3, 8'd4, 8'd6, 8'd4},
    '{3'd7, 1'b0, 1'b0, 16'd3, 16'd9, 16'd2, 8'd2, 8'd4, 8'd6, 8'd4},
    '{3'd4, 1'b0, 1'b0, 16'd3, 16'd9, 16'd2, 8'd1, 8'd4, 8'd6, 8'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      summary();
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; per_we = 1'b0; cc_we = '0; mc_clr = '0;
    ovf_clr = 1'b0; irq_en = '0; evt_en = '0; inv_en = '0;
    mode = '0; cnt_down = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input logic [2:0] md, input logic dn, input logic inv,
                       input logic [15:0] per, input logic [15:0] c0,
                       input logic [15:0] c1, input logic [NCH-1:0] ev);
    do_reset();
    mode = md; cnt_down = dn; inv_en = {2'b00, inv, 1'b0}; evt_en = ev;
    per_wdata = per; per_we = 1'b1;
    cc_wdata = {16'd0, 16'd0, c1, c0}; cc_we = 4'b0011;
    @(negedge clk);
    per_we = 1'b0; cc_we = '0;
  endtask

  task automatic run12(output int n_ovf, output int n_dma, output int n_mev,
                       output int n_hi, output int n_tr);
    logic prev;
    n_ovf = 0; n_dma = 0; n_mev = 0; n_hi = 0; n_tr = 0;
    tick = 1'b1;
    @(negedge clk);
    prev = wo[1];
    repeat (12) begin
      @(negedge clk);
      n_ovf += int'(ovf_evt);
      n_dma += int'(dma_req[1]);
      n_mev += int'(mc_evt[1]);
      n_hi  += int'(wo[1]);
      n_tr  += int'(wo[1] != prev);
      prev = wo[1];
    end
    tick = 1'b0;
  endtask

  initial begin
    int a_ovf, a_dma, a_mev, a_hi, a_tr;
    int first, cnt;
    logic [NCH-1:0] ref_wo;

    // R13: reset state
    do_reset();
    chk("R13 wo after reset", int'(wo), 0);
    chk("R13 mc_flag after reset", int'(mc_flag), 0);
    chk("R13 ovf_flag after reset", int'(ovf_flag), 0);
    chk("R13 irq after reset", int'(irq), 0);
    chk("R13 strobes after reset", int'({dma_req, mc_evt, ovf_evt}), 0);

    // Mode table: R1 R2 R3 R6 R7 R8 R9 R10 R12
    for (int r = 0; r < NV; r++) begin
      setup(VECS[r].md, VECS[r].dn, VECS[r].inv, VECS[r].per, VECS[r].cc0,
            VECS[r].cc1, 4'hF);
      run12(a_ovf, a_dma, a_mev, a_hi, a_tr);
      chk($sformatf("R9/R10 overflow count row %0d", r), a_ovf, int'(VECS[r].e_ovf));
      chk($sformatf("R12 dma count row %0d", r), a_dma, int'(VECS[r].e_dma));
      chk($sformatf("R12 event count row %0d", r), a_mev, int'(VECS[r].e_dma));
      chk($sformatf("R1/R2/R3/R6/R7/R8 high cycles row %0d", r), a_hi, int'(VECS[r].e_high));
      chk($sformatf("R1/R2/R3/R6/R7 transitions row %0d", r), a_tr, int'(VECS[r].e_trans));
    end

    // R12: event gated off, DMA still pulses
    setup(3'd0, 1'b0, 1'b0, 16'd3, 16'd9, 16'd1, 4'h0);
    run12(a_ovf, a_dma, a_mev, a_hi, a_tr);
    chk("R12 event disabled", a_mev, 0);
    chk("R12 dma with event disabled", a_dma, 3);

    // R11: flag timing, stickiness, irq, clear
    setup(3'd0, 1'b0, 1'b0, 16'd5, 16'd9, 16'd2, 4'h0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; mc_clr = '1;
    @(negedge clk);
    mc_clr = '0;
    chk("R11 flags cleared", int'(mc_flag), 0);
    tick = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 flag not yet set when count equals", int'(mc_flag[1]), 0);
    @(negedge clk);
    chk("R11 flag set one tick later", int'(mc_flag[1]), 1);
    tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 flag sticky", int'(mc_flag[1]), 1);
    chk("R11 irq masked", int'(irq), 0);
    irq_en = 4'b0010;
    #1;
    chk("R11 irq enabled", int'(irq), 1);
    @(negedge clk);
    mc_clr = 4'b0010;
    @(negedge clk);
    mc_clr = '0;
    chk("R11 flag cleared by write", int'(mc_flag[1]), 0);
    chk("R11 irq drops after clear", int'(irq), 0);

    // R4: single-slope buffered period waits for wrap
    setup(3'd2, 1'b0, 1'b0, 16'd4, 16'd9, 16'd2, 4'h0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; per_wdata = 16'd1; per_we = 1'b1;
    @(negedge clk);
    per_we = 1'b0;
    tick = 1'b1;
    first = 0; cnt = 0;
    for (int t = 1; t <= 8; t++) begin
      @(negedge clk);
      if (ovf_evt) begin
        cnt++;
        if (first == 0) first = t;
      end
    end
    tick = 1'b0;
    chk("R4 first wrap tick with old period", first, 5);
    chk("R4 wraps after update", cnt, 2);

    // R5: dual-slope buffered period waits for bottom
    setup(3'd6, 1'b0, 1'b0, 16'd3, 16'd9, 16'd2, 4'h0);
    tick = 1'b1;
    @(negedge clk);
    per_wdata = 16'd1; per_we = 1'b1;
    cnt = 0;
    for (int k = 2; k <= 13; k++) begin
      @(negedge clk);
      per_we = 1'b0;
      cnt += int'(ovf_evt);
    end
    tick = 1'b0;
    chk("R5 overflow count across bottom update", cnt, 7);

    // R2: no tick, no motion
    setup(3'd2, 1'b0, 1'b0, 16'd4, 16'd9, 16'd2, 4'h0);
    tick = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b0;
    ref_wo = wo;
    a_ovf = 0; a_dma = 0; a_tr = 0;
    repeat (10) begin
      @(negedge clk);
      a_ovf += int'(ovf_evt);
      a_dma += int'(|dma_req);
      a_tr  += int'(wo != ref_wo);
    end
    chk("R2 no overflow without tick", a_ovf, 0);
    chk("R2 no match without tick", a_dma, 0);
    chk("R2 outputs frozen without tick", a_tr, 0);

    summary();
  end
endmodule